// File: doc/BRIEF.md
# Serial Audio Transmitter

This block holds outgoing audio samples in a small transmit FIFO and shifts them out on a three-wire serial audio bus. It drives the bit clock, the word select line and the serial data line. The bit clock is made from the system clock. A programmable prescaler divides the system clock first, and a fixed divide-by-eight stage follows it. One bit period therefore lasts `cfg_div * 8` system clocks. Three framings are available: two-channel I2S, two-channel left-justified, and a TDM frame that is always 256 bit clocks long and carries a configurable number of slots.

Software, or a DMA engine, clears the FIFO first. It then preloads at least one word per channel and raises `tx_en`. Each channel slot takes one FIFO entry, and the left channel or slot 0 always comes first. A sample occupies the low `cfg_word_len` bits of an entry. It is sent MSB first and padded with zeros up to `cfg_chan_len`. A trigger interrupt flags the point at which the FIFO drains down to a programmed level. A sticky flag records any slot that started while the FIFO was empty.

Top module: `aud_ser_tx`

## Requirements
- R1: While `tx_en` is high, `sck` has a period of exactly `cfg_div*8` system clocks, with a value of 0 treated as 1. It is low for the first half of each bit and high for the second half. `ws` and `sd` change only on its falling edge.
- R2: Left-justified mode is `cfg_fmt=1`. `ws` is 0 for the left slot and 1 for the right slot, and each slot lasts `cfg_chan_len` bits. The MSB of each word is on `sd` in the same bit in which `ws` changes, and the left word is always sent before the right word.
- R3: I2S mode is `cfg_fmt=0`. `ws` is timed exactly as in R2, but the whole data stream is delayed by one bit. The MSB therefore appears one bit after the `ws` edge, and the last bit of a word spills into the first bit of the next slot.
- R4: TDM mode is `cfg_fmt=2`. A frame is 256 bits long. `ws` is high only during bit 0 of the frame. Slots 0 to `cfg_slots-1` each last `cfg_chan_len` bits and take FIFO words in slot order, MSB aligned with the slot start. All later bits of the frame are 0.
- R5: When `cfg_word_len < cfg_chan_len`, only the low `cfg_word_len` bits of a FIFO entry are sent, and the remaining bits of the slot are 0. Channel length goes up to 32.
- R6: Each active slot removes exactly one FIFO entry, in write order. A write while `fifo_full` is high is dropped. `fifo_level` reports the count, never exceeds DEPTH, and changes by at most one per cycle outside a clear.
- R7: A `fifo_clr` pulse empties the FIFO, so that `fifo_level` is 0 on the next cycle, and it also clears `underflow`.
- R8: A slot that starts while the FIFO is empty is sent as all zeros and sets `underflow`. `underflow` then stays high until `fifo_clr`.
- R9: `irq` goes high one cycle after `fifo_level` steps from `cfg_thresh+1` down to `cfg_thresh`. It stays high until an `irq_clr` pulse.
- R10: While `tx_en` is low, `sck`, `ws` and `sd` are held at 0 and no FIFO entry is consumed.
- R11: After reset, `sck`, `ws`, `sd`, `irq`, `underflow` and `fifo_level` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable |
| fifo_clr | input | 1 | Empties the FIFO and clears underflow |
| wr_valid | input | 1 | FIFO write strobe |
| wr_data | input | 32 | Sample to write; low `cfg_word_len` bits used |
| cfg_fmt | input | 2 | 0 I2S, 1 left-justified, 2 TDM |
| cfg_chan_len | input | 6 | Slot length in bits (8..32) |
| cfg_word_len | input | 6 | Sample length in bits (1..cfg_chan_len) |
| cfg_slots | input | 6 | Active slots per TDM frame |
| cfg_div | input | 8 | Prescaler value ahead of the /8 stage |
| cfg_thresh | input | 5 | Trigger level for the interrupt |
| irq_clr | input | 1 | Clears the pending interrupt |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Word select / frame sync |
| sd | output | 1 | Serial data |
| fifo_level | output | 5 | Number of entries held |
| fifo_full | output | 1 | FIFO full |
| irq | output | 1 | Pending trigger interrupt |
| underflow | output | 1 | Sticky empty-FIFO flag |

## Verification
The assertions are checked on every cycle. They cover the quiet bus while transmission is disabled, the bounded single-step motion and upper limit of the FIFO level, the effect of a clear, the stickiness of the interrupt and the underflow flag, and the interrupt firing after a downward step to the threshold. Some behaviour can only be shown by the bench's scenarios, because it depends on decoding whole frames against the words that were queued. This covers the slot ordering, the one-bit data delay of I2S, the TDM sync pulse and trailing zeros, the zero padding of short words, the measured bit-clock period for a given divider, and the dropping of writes into a full FIFO.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_TDM = 2'd2
  } fmt_e;

  localparam int TDM_FRAME_BITS = 256;
  localparam int FIX_DIV        = 8;
endpackage

// File: rtl/aud_tx_fifo.sv
module aud_tx_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int LVL_W = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              full,
  output logic [LVL_W-1:0]  level
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [LVL_W-1:0]  count;
  logic              do_push, do_pop;

  assign full    = (count == LVL_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];
  assign level   = count;

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/aud_tx_clkgen.sv
module aud_tx_clkgen #(
  parameter int DIV_W = 8,
  localparam int PH_W = $clog2(aud_tx_pkg::FIX_DIV)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             bit_tick,
  output logic             sck
);
  logic [DIV_W-1:0] pre;
  logic [DIV_W-1:0] div_eff;
  logic [PH_W-1:0]  phase;
  logic [PH_W-1:0]  phase_nx;
  logic             ce;

  assign div_eff  = (div == '0) ? DIV_W'(1) : div;
  assign ce       = (pre == div_eff - 1'b1);
  assign phase_nx = phase + 1'b1;
  // a bit boundary is the step from the last phase back to zero
  assign bit_tick = en && ce && (phase == '1);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pre   <= '0;
      phase <= '1;
      sck   <= 1'b0;
    end else begin
      pre <= ce ? '0 : pre + 1'b1;
      if (ce) begin
        phase <= phase_nx;
        sck   <= phase_nx[PH_W-1];
      end
    end
  end
endmodule

// File: rtl/aud_tx_framer.sv
module aud_tx_framer #(
  parameter int DATA_W = 32,
  parameter int CL_W   = 6,
  parameter int SLOT_W = 6,
  localparam int POS_W = $clog2(aud_tx_pkg::TDM_FRAME_BITS),
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               bit_tick,
  input  aud_tx_pkg::fmt_e   fmt,
  input  logic [CL_W-1:0]    chan_len,
  input  logic [CL_W-1:0]    word_len,
  input  logic [SLOT_W-1:0]  slots,
  input  logic [DATA_W-1:0]  head,
  input  logic               fifo_empty,
  output logic               pop,
  output logic               uf_evt,
  output logic               ws,
  output logic               sd
);
  import aud_tx_pkg::*;

  logic [POS_W-1:0]  pos;
  logic [CL_W-1:0]   bitc;
  logic [SLOT_W-1:0] slot;
  logic [DATA_W-1:0] cur_word;
  logic              prev_bit;

  logic [POS_W-1:0]  pos_last;
  logic [SLOT_W-1:0] nslots;
  logic              active, load;
  logic [DATA_W-1:0] mask, aligned;
  logic [CL_W-1:0]   sh;
  logic [IDX_W-1:0]  idx;
  logic              bit_now, ws_now;

  always_comb begin
    if (fmt == FMT_TDM) begin
      pos_last = POS_W'(TDM_FRAME_BITS - 1);
      nslots   = slots;
    end else begin
      pos_last = POS_W'({chan_len, 1'b0} - 1'b1);
      nslots   = SLOT_W'(2);
    end
    active = (slot < nslots);
    load   = active && (bitc == '0);
    mask   = (word_len >= CL_W'(DATA_W)) ? '1 : ((DATA_W'(1) << word_len) - 1'b1);
    sh     = CL_W'(DATA_W) - word_len;
    aligned = fifo_empty ? '0 : ((head & mask) << sh);
    idx    = IDX_W'(DATA_W - 1) - bitc[IDX_W-1:0];
    if (load)        bit_now = aligned[DATA_W-1];
    else if (active) bit_now = cur_word[idx];
    else             bit_now = 1'b0;
    ws_now = (fmt == FMT_TDM) ? (pos == '0) : (slot != '0);
  end

  assign pop    = bit_tick && load && !fifo_empty;
  assign uf_evt = bit_tick && load && fifo_empty;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pos      <= '0;
      bitc     <= '0;
      slot     <= '0;
      cur_word <= '0;
      prev_bit <= 1'b0;
      ws       <= 1'b0;
      sd       <= 1'b0;
    end else if (bit_tick) begin
      ws <= ws_now;
      if (fmt == FMT_I2S) begin
        sd       <= prev_bit;
        prev_bit <= bit_now;
      end else begin
        sd <= bit_now;
      end
      if (load) cur_word <= aligned;
      if (pos == pos_last) begin
        pos  <= '0;
        bitc <= '0;
        slot <= '0;
      end else begin
        pos <= pos + 1'b1;
        if (bitc == chan_len - 1'b1) begin
          bitc <= '0;
          slot <= (slot == '1) ? slot : slot + 1'b1;
        end else begin
          bitc <= bitc + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int DIV_W  = 8,
  parameter int CL_W   = 6,
  parameter int SLOT_W = 6,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              fifo_clr,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        cfg_fmt,
  input  logic [CL_W-1:0]   cfg_chan_len,
  input  logic [CL_W-1:0]   cfg_word_len,
  input  logic [SLOT_W-1:0] cfg_slots,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [LVL_W-1:0]  cfg_thresh,
  input  logic              irq_clr,
  output logic              sck,
  output logic              ws,
  output logic              sd,
  output logic [LVL_W-1:0]  fifo_level,
  output logic              fifo_full,
  output logic              irq,
  output logic              underflow
);
  import aud_tx_pkg::*;

  fmt_e              fmt;
  logic              bit_tick, pop, uf_evt, empty;
  logic [DATA_W-1:0] head;
  logic [LVL_W-1:0]  lvl_q;

  assign fmt = fmt_e'(cfg_fmt);

  aud_tx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .clr(fifo_clr),
    .push(wr_valid), .push_data(wr_data),
    .pop(pop), .head(head), .empty(empty), .full(fifo_full),
    .level(fifo_level)
  );

  aud_tx_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .en(tx_en), .div(cfg_div),
    .bit_tick(bit_tick), .sck(sck)
  );

  aud_tx_framer #(.DATA_W(DATA_W), .CL_W(CL_W), .SLOT_W(SLOT_W)) u_frm (
    .clk(clk), .rst(rst), .en(tx_en), .bit_tick(bit_tick), .fmt(fmt),
    .chan_len(cfg_chan_len), .word_len(cfg_word_len), .slots(cfg_slots),
    .head(head), .fifo_empty(empty), .pop(pop), .uf_evt(uf_evt),
    .ws(ws), .sd(sd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q     <= '0;
      irq       <= 1'b0;
      underflow <= 1'b0;
    end else begin
      lvl_q <= fifo_level;
      if (({1'b0, lvl_q} == {1'b0, cfg_thresh} + 1'b1) && (fifo_level == cfg_thresh))
        irq <= 1'b1;
      else if (irq_clr)
        irq <= 1'b0;
      if (fifo_clr)    underflow <= 1'b0;
      else if (uf_evt) underflow <= 1'b1;
    end
  end
endmodule

// File: rtl/aud_ser_tx_chk.sv
module aud_ser_tx_chk #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_en,
  input logic             fifo_clr,
  input logic             irq_clr,
  input logic [LVL_W-1:0] cfg_thresh,
  input logic             sck,
  input logic             ws,
  input logic             sd,
  input logic [LVL_W-1:0] fifo_level,
  input logic             irq,
  input logic             underflow
);
  a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (!sck && !ws && !sd));

  a_r6_level_bound: assert property (@(posedge clk) disable iff (rst)
    {1'b0, fifo_level} <= (LVL_W + 1)'(DEPTH));

  a_r6_level_step: assert property (@(posedge clk) disable iff (rst)
    !$past(fifo_clr) |->
      (({1'b0, fifo_level} <= {1'b0, $past(fifo_level)} + 1'b1) &&
       ({1'b0, $past(fifo_level)} <= {1'b0, fifo_level} + 1'b1)));

  a_r7_clear_empties: assert property (@(posedge clk) disable iff (rst)
    fifo_clr |=> (fifo_level == '0 && !underflow));

  a_r8_uf_sticky: assert property (@(posedge clk) disable iff (rst)
    (underflow && !fifo_clr) |=> underflow);

  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);

  a_r9_irq_fires: assert property (@(posedge clk) disable iff (rst)
    (({1'b0, $past(fifo_level)} == {1'b0, cfg_thresh} + 1'b1) &&
     (fifo_level == cfg_thresh)) |=> irq);
endmodule

bind aud_ser_tx aud_ser_tx_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .tx_en(tx_en), .fifo_clr(fifo_clr),
  .irq_clr(irq_clr), .cfg_thresh(cfg_thresh), .sck(sck), .ws(ws), .sd(sd),
  .fifo_level(fifo_level), .irq(irq), .underflow(underflow)
);

// File: tb/aud_ser_tx_bench.sv
module aud_ser_tx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_en = 1'b0, fifo_clr = 1'b0, wr_valid = 1'b0, irq_clr = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  cfg_fmt = 2'd1;
  logic [5:0]  cfg_chan_len = 6'd16, cfg_word_len = 6'd16, cfg_slots = 6'd2;
  logic [7:0]  cfg_div = 8'd1;
  logic [4:0]  cfg_thresh = 5'd0;
  logic        sck, ws, sd, fifo_full, irq, underflow;
  logic [4:0]  fifo_level;

  always #2 clk = ~clk;

  aud_ser_tx u_aud_ser_tx (
    .clk(clk), .rst(rst), .tx_en(tx_en), .fifo_clr(fifo_clr),
    .wr_valid(wr_valid), .wr_data(wr_data), .cfg_fmt(cfg_fmt),
    .cfg_chan_len(cfg_chan_len), .cfg_word_len(cfg_word_len),
    .cfg_slots(cfg_slots), .cfg_div(cfg_div), .cfg_thresh(cfg_thresh),
    .irq_clr(irq_clr), .sck(sck), .ws(ws), .sd(sd),
    .fifo_level(fifo_level), .fifo_full(fifo_full), .irq(irq),
    .underflow(underflow)
  );

  int          n_tests = 0, n_fail = 0;
  bit          finished = 0;
  logic [31:0] exp_q[$];
  string       tag = "R2";
  bit          mon_on = 0;
  int          k = 0;
  bit          prev_lj = 0, sck_prev = 0;
  logic [31:0] cur = '0;
  longint      cyc = 0, last_rise = 0, last_per = 0;

  task automatic check(bit ok, string req, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_tb();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: rebuilds expected ws/sd per bit and compares at each sck rise
  always @(negedge clk) begin
    if (mon_on && sck && !sck_prev) begin
      int flen, pos, slot, b, ns;
      bit lj, exp_sd, exp_ws;
      last_per  = cyc - last_rise;
      last_rise = cyc;
      flen = (cfg_fmt == 2'd2) ? 256 : 2 * int'(cfg_chan_len);
      ns   = (cfg_fmt == 2'd2) ? int'(cfg_slots) : 2;
      pos  = k % flen;
      slot = pos / int'(cfg_chan_len);
      b    = pos % int'(cfg_chan_len);
      if (b == 0 && slot < ns) cur = (exp_q.size() > 0) ? exp_q.pop_front() : 32'd0;
      lj = (slot < ns && b < int'(cfg_word_len)) ? cur[int'(cfg_word_len) - 1 - b] : 1'b0;
      exp_ws = (cfg_fmt == 2'd2) ? (pos == 0) : (slot == 1);
      if (cfg_fmt == 2'd0) begin
        exp_sd  = prev_lj;
        prev_lj = lj;
      end else begin
        exp_sd = lj;
      end
      check({ws, sd} == {exp_ws, exp_sd}, tag, {ws, sd}, {exp_ws, exp_sd});
      k++;
    end
    sck_prev = sck;
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cfg(logic [1:0] f, int cl, int wl, int sl, int dv);
    tick(1);
    cfg_fmt = f; cfg_chan_len = 6'(cl); cfg_word_len = 6'(wl);
    cfg_slots = 6'(sl); cfg_div = 8'(dv);
  endtask

  task automatic clear_fifo();
    tick(1); fifo_clr = 1; tick(1); fifo_clr = 0;
    exp_q.delete();
  endtask

  // driver: writes one word and records it unless the FIFO is full
  task automatic push_word(logic [31:0] w);
    tick(1);
    if (!fifo_full) exp_q.push_back(w);
    wr_valid = 1; wr_data = w;
    tick(1);
    wr_valid = 0;
  endtask

  task automatic run_frames(int nfr);
    int flen;
    flen = (cfg_fmt == 2'd2) ? 256 : 2 * int'(cfg_chan_len);
    tick(1);
    k = 0; prev_lj = 0; sck_prev = 0; mon_on = 1; tx_en = 1;
    while (k < nfr * flen) tick(1);
    tx_en = 0; mon_on = 0;
    tick(2);
  endtask

  initial begin
    tick(3);
    rst = 0;
    tick(1);
    // R11: reset state
    check({sck, ws, sd, irq, underflow} == 5'b0, "R11", {sck, ws, sd, irq, underflow}, 0);
    check(fifo_level == 0, "R11", fifo_level, 0);

    // R2 left-justified, full-width words; also R10 idle check before enable
    cfg(2'd1, 16, 16, 2, 1);
    clear_fifo();
    for (int i = 0; i < 16; i++) push_word(32'hA5C30000 ^ (i * 32'h1357));
    tick(40);
    check(fifo_level == 16, "R10", fifo_level, 16);
    check({sck, ws, sd} == 3'b0, "R10", {sck, ws, sd}, 0);
    tag = "R2";
    run_frames(9);
    check(exp_q.size() == 0, "R6", exp_q.size(), 0);
    // R8: final frame ran from an empty FIFO
    check(underflow == 1, "R8", underflow, 1);
    tick(20);
    check(underflow == 1, "R8", underflow, 1);
    check({sck, ws, sd} == 3'b0, "R10", {sck, ws, sd}, 0);
    // R7: clear drops underflow
    clear_fifo();
    tick(1);
    check(underflow == 0, "R7", underflow, 0);

    // R3 I2S, 32-bit slots with 24-bit words (R5 padding)
    cfg(2'd0, 32, 24, 2, 2);
    clear_fifo();
    for (int i = 0; i < 6; i++) push_word(32'h89ABCDEF + i * 32'h01020304);
    tag = "R3";
    run_frames(4);
    check(exp_q.size() == 0, "R3", exp_q.size(), 0);

    // R4 TDM, 4 slots of 32 bits in a 256-bit frame
    cfg(2'd2, 32, 32, 4, 1);
    clear_fifo();
    for (int i = 0; i < 8; i++) push_word(32'hF00D0001 * (i + 3));
    tag = "R4";
    run_frames(3);
    check(exp_q.size() == 0, "R4", exp_q.size(), 0);

    // R1 bit period for divider 3, R5 short words in 24-bit slots
    cfg(2'd1, 24, 20, 2, 3);
    clear_fifo();
    for (int i = 0; i < 10; i++) push_word(32'h7FFFFFFF - i * 32'h00311111);
    tag = "R5";
    run_frames(6);
    check(last_per == 24, "R1", last_per, 24);

    // R6 writes into a full FIFO are dropped
    cfg(2'd1, 8, 8, 2, 1);
    clear_fifo();
    for (int i = 0; i < 17; i++) push_word(32'h00000011 * (i + 1));
    check(fifo_full == 1, "R6", fifo_full, 1);
    check(fifo_level == 16, "R6", fifo_level, 16);
    check(exp_q.size() == 16, "R6", exp_q.size(), 16);
    tag = "R6";
    run_frames(9);

    // R9 trigger interrupt at threshold 3
    cfg(2'd1, 16, 16, 2, 1);
    clear_fifo();
    tick(1); irq_clr = 1; tick(1); irq_clr = 0;
    cfg_thresh = 5'd3;
    for (int i = 0; i < 8; i++) push_word(32'h0000BEE0 + i);
    check(irq == 0, "R9", irq, 0);
    tag = "R9";
    run_frames(5);
    check(irq == 1, "R9", irq, 1);
    tick(10);
    check(irq == 1, "R9", irq, 1);
    tick(1); irq_clr = 1; tick(1); irq_clr = 0;
    tick(1);
    check(irq == 0, "R9", irq, 0);

    finish_tb();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_tb();
  end
endmodule